// File: doc/BRIEF.md
# Synchronous Graphics DRAM Burst Engine with Stop

This block models the device side of a synchronous graphics DRAM data path. On every rising clock edge it samples chip-select, RAS, CAS and WE and decodes them into one of four commands. A READ or WRITE starts a burst of a programmed length at a column address. Read data comes back on a 32-bit output after a programmable CAS latency of 1, 2 or 3 clocks. Write data is taken from the DQ input on the command edge and on each edge after it. The storage is a small internal register file that the column address indexes.

A burst-stop command cuts a burst short. For a read, the beats already in the latency pipeline still go out, so the output stops exactly one CAS latency after the stop. For a write, DQ input is ignored from the stop edge onward. Holding chip-select high deselects the device. The command pins and the address are then ignored, and the cycle acts as a no-operation. Any burst in progress keeps running. A new READ or WRITE cuts off the burst that is running and starts its own.

Top module: `sgram_burst_core`

## Requirements
- R1: With cs_n low, the pins {ras_n,cas_n,we_n} decode as follows: 3'b101 is READ, 3'b100 is WRITE and 3'b110 is burst stop. Every other pattern is a no-operation.
- R2: Let a READ be sampled at edge k, with cas_lat set to CL (1, 2 or 3). Beat n of the burst is driven on dq_out with dq_oe high in the cycle that follows edge k+CL-1+n. A controller therefore captures it at edge k+CL+n.
- R3: The code on burst_len selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. The code is captured with the command. Beat n uses the starting column with its low log2(length) bits replaced by (start+n) modulo the length. The upper bits are kept.
- R4: Let a burst stop be sampled at edge s during a read. Beats issued at edges before s are still driven. No beat is issued at or after s, so dq_oe is low from the cycle after edge s+CL-1, unless a later READ drives it.
- R5: Let a WRITE be sampled at edge k. The dq_in value sampled at edge k+n is stored at the column of beat n.
- R6: The dq_in value sampled at the edge of a burst stop, or at any later edge, is not written for the stopped write burst. Those columns keep their previous contents.
- R7: With cs_n high, ras_n, cas_n, we_n and col_addr are ignored. An active burst continues exactly as it would under a no-operation.
- R8: A READ or WRITE sampled during an active burst ends that burst. The new burst starts its beat 0 on the same edge. Read beats already in the latency pipeline are still driven.
- R9: dq_oe is low and dq_out is all zeros in every cycle in which no read beat is due.
- R10: While reset is asserted, dq_oe is low and dq_out is zero, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all pins are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cs_n | input | 1 | Chip select, active low; when high, the device is deselected |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| col_addr | input | COL_W | Starting column of a READ or WRITE |
| cas_lat | input | 2 | CAS latency in clocks (1, 2 or 3) |
| burst_len | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 beats |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | High in cycles that carry a read beat |

## Verification
The bench builds the block with its defaults: DATA_W=32 and COL_W=4. This gives a 16-word array in which a length-8 burst fills half the columns. Random commands therefore keep landing on wrapped columns and on words written a few cycles earlier. All three latency settings and all four length codes are run. With these settings, directed cases can pin down the edge of the first beat, the edge of the last beat after a stop, and the old contents that survive a stopped write.

// File: rtl/sgram_pkg.sv
package sgram_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  // Pin-level decode; deselect masks every other pin.
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b101:  c = CMD_READ;
        3'b100:  c = CMD_WRITE;
        3'b110:  c = CMD_STOP;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sgram_rst_sync.sv
module sgram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sgram_burst_ctrl.sv
module sgram_burst_ctrl
  import sgram_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int BL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [COL_W-1:0] addr,
  input  logic [BL_W-1:0]  bl_code,
  output logic             rd_go,
  output logic             wr_go,
  output logic [COL_W-1:0] col,
  output logic             busy
);
  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic [COL_W-1:0] start_q, start_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] mask_new;
  logic [COL_W-1:0] wrap_sum;
  logic             st_en;

  // Burst-length code to a wrap mask of low column bits.
  always_comb begin
    mask_new = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < int'(bl_code)) mask_new[i] = 1'b1;
    end
  end

  assign wrap_sum = start_q + cnt_q;

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    start_d = start_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    rd_go   = 1'b0;
    wr_go   = 1'b0;
    col     = (start_q & ~mask_q) | (wrap_sum & mask_q);
    unique case (cmd)
      CMD_READ, CMD_WRITE: begin
        act_d   = |mask_new;
        wr_d    = (cmd == CMD_WRITE);
        start_d = addr;
        mask_d  = mask_new;
        cnt_d   = COL_W'(1);
        col     = addr;
        rd_go   = (cmd == CMD_READ);
        wr_go   = (cmd == CMD_WRITE);
      end
      CMD_STOP: begin
        act_d = 1'b0;
      end
      default: begin
        if (act_q) begin
          rd_go = !wr_q;
          wr_go = wr_q;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == mask_q) act_d = 1'b0;
        end
      end
    endcase
  end

  assign st_en = (cmd != CMD_NOP) || act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      start_q <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else if (st_en) begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      start_q <= start_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = act_q;

  AST_STOP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP) |=> !act_q); // R4

  AST_BEAT_INSIDE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ((cnt_q & ~mask_q) == '0) && (cnt_q != '0)); // R3

  AST_NEW_CMD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ || cmd == CMD_WRITE) |=> (start_q == $past(addr))); // R8
endmodule

// File: rtl/sgram_array.sv
module sgram_array #(
  parameter int DATA_W = 32,
  parameter int COL_W  = 4,
  localparam int DEPTH = 1 << COL_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_arr [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q;
    assign hit = we && (waddr == COL_W'(w));
    always_ff @(posedge clk) begin
      if (hit) word_q <= wdata;
    end
    assign word_arr[w] = word_q;
  end

  assign rdata = word_arr[raddr];
endmodule

// File: rtl/sgram_read_pipe.sv
module sgram_read_pipe #(
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CL_W-1:0]   cas_lat,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  localparam int SEL_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic [MAX_CL-1:0] vld_vec;
  logic [DATA_W-1:0] dat_arr [MAX_CL];
  logic [SEL_W-1:0]  sel;

  for (genvar s = 0; s < MAX_CL; s++) begin : g_stage
    logic              v_in;
    logic [DATA_W-1:0] d_in;
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    if (s == 0) begin : g_head
      assign v_in = in_vld;
      assign d_in = in_data;
    end else begin : g_tail
      assign v_in = vld_vec[s-1];
      assign d_in = dat_arr[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_in;
    end
    always_ff @(posedge clk) begin
      if (v_in) d_q <= d_in;
    end
    assign vld_vec[s] = v_q;
    assign dat_arr[s] = d_q;
  end

  // Latency 0 is not a legal setting and is treated as 1.
  always_comb begin
    if (cas_lat == '0)                 sel = '0;
    else if (int'(cas_lat) > MAX_CL)   sel = SEL_W'(MAX_CL - 1);
    else                               sel = SEL_W'(cas_lat - 1'b1);
  end

  assign out_vld  = vld_vec[sel];
  assign out_data = out_vld ? dat_arr[sel] : '0;

  AST_CL1_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cas_lat == 2'd1) |=> out_vld); // R2

  AST_CL2_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cas_lat == 2'd2 && $stable(cas_lat)) |-> ##2 out_vld); // R2

  AST_CL3_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cas_lat == 2'd3 && $stable(cas_lat)) |-> ##3 out_vld); // R2
endmodule

// File: rtl/sgram_burst_core.sv
module sgram_burst_core
  import sgram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [1:0]        cas_lat,
  input  logic [1:0]        burst_len,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int MAX_CL = 3;

  logic              rst_n_sync;
  cmd_e              cmd;
  logic              rd_go;
  logic              wr_go;
  logic              busy;
  logic [COL_W-1:0]  col;
  logic [DATA_W-1:0] rdata;

  sgram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign cmd = decode_pins(cs_n, ras_n, cas_n, we_n);

  sgram_burst_ctrl #(.COL_W(COL_W), .BL_W(2)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .cmd     (cmd),
    .addr    (col_addr),
    .bl_code (burst_len),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .col     (col),
    .busy    (busy)
  );

  sgram_array #(.DATA_W(DATA_W), .COL_W(COL_W)) u_mem (
    .clk   (clk),
    .we    (wr_go),
    .waddr (col),
    .wdata (dq_in),
    .raddr (col),
    .rdata (rdata)
  );

  sgram_read_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL), .CL_W(2)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_vld   (rd_go),
    .in_data  (rdata),
    .cas_lat  (cas_lat),
    .out_vld  (dq_oe),
    .out_data (dq_out)
  );

  AST_STOP_MASKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!cs_n && ras_n && cas_n && !we_n) |-> !wr_go); // R6

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cs_n && !busy) |-> !(rd_go || wr_go)); // R7

  AST_ONE_BEAT_KIND: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(rd_go && wr_go)); // R1
endmodule

// File: tb/sim_sgram_burst_core.sv
`timescale 1ns/1ps
module sim_sgram_burst_core;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic          cs_n, ras_n, cas_n, we_n;
  logic [CW-1:0] col_addr;
  logic [1:0]    cas_lat;
  logic [1:0]    burst_len;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  sgram_burst_core #(.DATA_W(DW), .COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .col_addr(col_addr), .cas_lat(cas_lat), .burst_len(burst_len),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int e = 0;
  int cl = 1;

  // Bench model of the requirements
  logic [DW-1:0] mm [16];
  bit            exp_oe [8];
  logic [DW-1:0] exp_dq [8];
  bit  m_act = 0, m_wr = 0;
  int  m_start = 0, m_len = 1, m_cnt = 0;
  int  first_oe, last_oe, n_oe;

  localparam int C_NOP = 0, C_RD = 1, C_WR = 2, C_ST = 3;

  function automatic int f_col(int st, int n, int len);
    return ((st & ~(len - 1)) | ((st + n) & (len - 1))) & 15;
  endfunction

  task automatic report_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_edge(input bit cs, input int c, input int a, input logic [DW-1:0] d, input int b);
    bit rd = 0;
    bit wr = 0;
    int col = 0;
    int cc;
    int slot;
    cc = cs ? C_NOP : c;
    if (cc == C_RD || cc == C_WR) begin
      m_start = a; m_len = 1 << b; m_wr = (cc == C_WR);
      col = a; rd = (cc == C_RD); wr = (cc == C_WR);
      m_cnt = 1; m_act = (m_len > 1);
    end else if (cc == C_ST) begin
      m_act = 0;
    end else if (m_act) begin
      col = f_col(m_start, m_cnt, m_len);
      rd = !m_wr; wr = m_wr;
      m_cnt++;
      if (m_cnt == m_len) m_act = 0;
    end
    slot = (e + cl - 1) % 8;
    exp_oe[slot] = rd;
    exp_dq[slot] = rd ? mm[col] : '0;
    if (wr) mm[col] = d;
  endtask

  task automatic check_cycle(input string req);
    int slot;
    slot = e % 8;
    n_chk++;
    if (dq_oe !== exp_oe[slot] || dq_out !== exp_dq[slot]) begin
      n_bad++;
      $display("FAIL %s: edge %0d oe=%0b dq=%h expected oe=%0b dq=%h",
               req, e, dq_oe, dq_out, exp_oe[slot], exp_dq[slot]);
    end
    if (dq_oe === 1'b1) begin
      if (first_oe < 0) first_oe = e;
      last_oe = e;
      n_oe++;
    end
    exp_oe[slot] = 0;
    exp_dq[slot] = '0;
  endtask

  // Called at a negedge; drives one command, lets one edge pass, checks.
  task automatic step(input bit cs, input int c, input int a, input logic [DW-1:0] d,
                      input int b, input string req);
    cs_n = cs;
    if (cs) {ras_n, cas_n, we_n} = 3'($urandom);
    else begin
      case (c)
        C_RD:    {ras_n, cas_n, we_n} = 3'b101;
        C_WR:    {ras_n, cas_n, we_n} = 3'b100;
        C_ST:    {ras_n, cas_n, we_n} = 3'b110;
        default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
    end
    col_addr  = CW'(a);
    dq_in     = d;
    burst_len = 2'(b);
    model_edge(cs, c, a, d, b);
    @(posedge clk);
    @(negedge clk);
    check_cycle(req);
    e++;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, C_NOP, 0, '0, 0, req);
  endtask

  function automatic logic [DW-1:0] pat(input int k, input int i);
    return 32'hA500_0000 ^ (k << 16) ^ (i * 32'h0000_1111);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report_summary();
    $finish;
  end

  initial begin
    int r_edge, s_edge;
    void'($urandom(32'd5127));
    for (int i = 0; i < 8; i++) begin exp_oe[i] = 0; exp_dq[i] = '0; end
    for (int i = 0; i < 16; i++) mm[i] = '0;
    rst_n = 1'b0; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
    col_addr = '0; cas_lat = 2'd1; burst_len = 2'd0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", dq_oe === 1'b0, int'(dq_oe), 0);
    chk("R10 dq in reset", dq_out === '0, int'(dq_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 1; k <= 3; k++) begin
      cl = k;
      cas_lat = 2'(k);
      idle(4, "R9");
      // Fill the whole array with two 8-beat writes
      for (int i = 0; i < 8; i++) step(0, (i == 0) ? C_WR : C_NOP, 0, pat(k, i), 3, "R5");
      for (int i = 0; i < 8; i++) step(0, (i == 0) ? C_WR : C_NOP, 8, pat(k, i + 8), 3, "R5");
      // Wrapped 8-beat read from column 5
      step(0, C_RD, 5, '0, 3, "R3");
      idle(10, "R3");
      // Length 1 and length 2 reads
      step(0, C_RD, 11, '0, 0, "R3");
      step(0, C_RD, 7, '0, 1, "R3");
      idle(5, "R9");
      // Read cut by a stop after three beats
      first_oe = -1; last_oe = -1; n_oe = 0;
      r_edge = e;
      step(0, C_RD, 2, '0, 3, "R4");
      idle(2, "R4");
      s_edge = e;
      step(0, C_ST, 0, '0, 0, "R4");
      idle(6, "R4");
      chk("R2 first beat edge", first_oe == r_edge + cl - 1, first_oe, r_edge + cl - 1);
      chk("R4 last beat edge", last_oe == s_edge + cl - 2, last_oe, s_edge + cl - 2);
      chk("R4 beat count", n_oe == 3, n_oe, 3);
      // Write cut by a stop; later beats must not land
      step(0, C_WR, 8, 32'hDEAD_0000 + k, 3, "R6");
      step(0, C_NOP, 0, 32'hDEAD_0100 + k, 0, "R6");
      step(0, C_ST, 0, 32'hDEAD_0200 + k, 0, "R6");
      step(0, C_NOP, 0, 32'hDEAD_0300 + k, 0, "R6");
      step(0, C_NOP, 0, 32'hDEAD_0400 + k, 0, "R6");
      step(0, C_RD, 8, '0, 3, "R6");
      idle(11, "R6");
      // Deselect with garbage on the pins during a read burst
      step(0, C_RD, 0, '0, 2, "R7");
      for (int i = 0; i < 5; i++) step(1, C_WR, 15, 32'hFFFF_FFFF, 3, "R7");
      idle(4, "R7");
      // Truncation by new commands
      step(0, C_RD, 0, '0, 3, "R8");
      idle(2, "R8");
      step(0, C_RD, 12, '0, 2, "R8");
      step(0, C_NOP, 0, '0, 0, "R8");
      step(0, C_WR, 4, 32'hBEEF_0000 + k, 3, "R8");
      step(0, C_NOP, 0, 32'hBEEF_0100 + k, 0, "R8");
      step(0, C_RD, 4, '0, 1, "R8");
      idle(6, "R8");
      // Random command mix
      for (int i = 0; i < 150; i++) begin
        int c;
        bit cs;
        c  = int'($urandom % 6);
        if (c > 3) c = C_NOP;
        cs = ($urandom % 5) == 0;
        step(cs, c, int'($urandom % 16), $urandom, int'($urandom % 4), "R1");
      end
      step(0, C_ST, 0, '0, 0, "R1");
      idle(5, "R9");
    end

    report_summary();
    $finish;
  end
endmodule